// File: doc/BRIEF.md
# System Clock Source Selector and Divider

This block chooses where the system clock comes from and how far it is divided. The block runs on one fast sampling clock. Each oscillator arrives as a one-cycle tick strobe: main oscillator, internal 16 MHz oscillator, low-frequency internal oscillator, 32.768 kHz external oscillator, and the PLL output. From the selected source the block produces a one-cycle clock-enable pulse, `clk_en`, once every N ticks. Logic downstream uses that pulse as its system clock enable.

Software programs the block through two configuration words. The first is a compact legacy word. The second is an extended word with a wider divisor, an extra source code and an extra divisor bit for the undivided PLL path. An override bit in the extended word decides which word drives the clock tree. The decoded configuration is checked before it is taken. An illegal combination leaves the running configuration unchanged and raises an error flag. The effective source, path and divisor are reported on status outputs. A PLL-lock input is mirrored into bit 6 of a raw status byte, so software can wait for lock before it leaves bypass.

Top module: `sysclk_seldiv`

Legacy word fields:
- Divisor [3:0]
- Source [5:4]
- Bypass [6]
- PLL power-down [7]
- Divider enable [8]
- Main oscillator off [9]

Extended word fields:
- Divisor [5:0]
- Extra divisor LSB [6]
- Source [9:7]
- Bypass [10]
- PLL power-down [11]
- Undivided-PLL select [12]
- Override [13]

## Requirements
- R1: After reset the legacy word reads 0x2DF: divisor 15, source 1, bypass set, power-down set, divider enable clear, main oscillator off. The extended word reads 0xC8F: divisor 15, source 1, bypass set, power-down set. The effective outputs show source 1, oscillator path, divisor 0, no error, and `raw_status` reads 0.
- R2: Source codes are 0 = main, 1 = internal, 2 = internal divided by 4, 3 = low-frequency, and 7 = 32.768 kHz external; 7 is reachable only through the extended word. Codes 4 to 6 are reserved. Programming a reserved code sets `cfg_err` and holds the previous effective configuration.
- R3: With the override bit (extended bit 13) set, the extended word's source, bypass, power-down and divisor fields are used. With it clear, the extended word has no effect on any output. The divider-enable bit always comes from the legacy word.
- R4: With bypass clear the divider counts PLL ticks pre-divided by 2, and `eff_pll` is 1. With bypass set it counts ticks of the selected oscillator.
- R5: The divide ratio is the divisor value plus one. The legacy field gives ratios 1 to 16 and the extended field gives ratios 1 to 64. `eff_div` reports the value, not the ratio.
- R6: With extended bit 12 set on the PLL path, the divisor is {extended divisor, extra LSB}, a 7-bit value, applied to undivided PLL ticks. With bit 12 clear, the extra LSB is ignored.
- R7: A write to the extended word updates the extra LSB (bit 6) only when the written data has bit 12 set. Otherwise the stored LSB is kept.
- R8: On the oscillator path with divider enable clear, the ratio is 1 (`eff_div` = 0). On the PLL path the divider is used whatever the divider-enable bit holds.
- R9: On the PLL path a divisor field of 0 or 1 is reserved. It sets `cfg_err` and holds the previous effective configuration.
- R10: `raw_status` bit 6 follows `pll_locked` after LOCK_STAGES clock cycles. All other bits of `raw_status` stay 0.
- R11: `clk_en` is a one-cycle pulse once every ratio ticks of the selected source. The count restarts when the effective configuration changes, so with a tick on every cycle the first pulse comes ratio cycles after the new `eff_div` appears.
- R12: A write is visible on `legacy_q`/`ext_q` one cycle after the write strobe. The effective outputs and `cfg_err` follow one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_legacy | input | 1 | Write strobe for the legacy word |
| wr_ext | input | 1 | Write strobe for the extended word |
| wdata | input | DATA_W | Write data |
| tick_main | input | 1 | Main oscillator tick |
| tick_int | input | 1 | Internal 16 MHz oscillator tick |
| tick_lfo | input | 1 | Low-frequency internal oscillator tick |
| tick_x32k | input | 1 | 32.768 kHz external oscillator tick |
| tick_pll | input | 1 | PLL output tick |
| pll_locked | input | 1 | PLL lock indication |
| clk_en | output | 1 | Divided clock-enable pulse |
| eff_src | output | 3 | Effective source code |
| eff_pll | output | 1 | Effective path is the PLL |
| eff_pll_off | output | 1 | Effective PLL power-down |
| eff_div | output | 7 | Effective divisor value (ratio minus one) |
| cfg_err | output | 1 | Last decoded configuration was reserved |
| raw_status | output | 8 | Raw status byte; bit 6 is PLL lock |
| main_osc_off | output | 1 | Main oscillator disable from the legacy word |
| legacy_q | output | DATA_W | Legacy word readback |
| ext_q | output | DATA_W | Extended word readback |

## Verification
A write shows up on the readback ports one cycle after its strobe. It reaches the effective outputs and `cfg_err` one cycle after that. The bench therefore samples the readback one cycle after the write, and compares the effective outputs two or more cycles later, always on the falling edge. The lock bit is due LOCK_STAGES cycles after `pll_locked` changes, and the bench checks that it is still low one cycle earlier. Divided-clock checks measure the gap between two consecutive `clk_en` pulses, which does not depend on phase. The restart check counts cycles from the first sample showing the new `eff_div` to the first pulse, which must equal the ratio when there is a tick every cycle.

// File: rtl/sysclk_seldiv_pkg.sv
package sysclk_seldiv_pkg;

   localparam int LDIV_W = 4;
   localparam int XDIV_W = 6;
   localparam int EDIV_W = XDIV_W + 1;
   localparam int SRC_W  = 3;

   // legacy word layout
   localparam int LG_DIV  = 0;
   localparam int LG_SRC  = LG_DIV + LDIV_W;
   localparam int LG_BYP  = LG_SRC + 2;
   localparam int LG_PDN  = LG_BYP + 1;
   localparam int LG_DEN  = LG_PDN + 1;
   localparam int LG_MOFF = LG_DEN + 1;
   localparam int LG_W    = LG_MOFF + 1;

   // extended word layout
   localparam int XT_DIV  = 0;
   localparam int XT_LSB  = XT_DIV + XDIV_W;
   localparam int XT_SRC  = XT_LSB + 1;
   localparam int XT_BYP  = XT_SRC + SRC_W;
   localparam int XT_PDN  = XT_BYP + 1;
   localparam int XT_D400 = XT_PDN + 1;
   localparam int XT_OVR  = XT_D400 + 1;
   localparam int XT_W    = XT_OVR + 1;

   localparam logic [SRC_W-1:0] SRC_MAIN = 3'd0;
   localparam logic [SRC_W-1:0] SRC_INT  = 3'd1;
   localparam logic [SRC_W-1:0] SRC_INTQ = 3'd2;
   localparam logic [SRC_W-1:0] SRC_LFO  = 3'd3;
   localparam logic [SRC_W-1:0] SRC_X32K = 3'd7;

   localparam logic [LG_W-1:0] LG_RST = LG_W'(10'h2DF);
   localparam logic [XT_W-1:0] XT_RST = XT_W'(14'h0C8F);

   localparam int PLL_MIN_FIELD = 2;

   typedef struct packed {
      logic [SRC_W-1:0]  src;
      logic              pll;
      logic              pll_off;
      logic              raw_pll;
      logic [EDIV_W-1:0] div;
   } eff_cfg_t;

   localparam eff_cfg_t EFF_RST = '{src: SRC_INT, pll: 1'b0, pll_off: 1'b1,
                                    raw_pll: 1'b0, div: '0};

   function automatic logic src_reserved(input logic [SRC_W-1:0] s);
      return (s == 3'd4) || (s == 3'd5) || (s == 3'd6);
   endfunction

endpackage

// File: rtl/sysclk_cfg_regs.sv
module sysclk_cfg_regs
   import sysclk_seldiv_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_legacy,
   input  logic              wr_ext,
   input  logic [DATA_W-1:0] wdata,
   output logic [LG_W-1:0]   leg_r,
   output logic [XT_W-1:0]   ext_r
);

   logic [XT_W-1:0] ext_next;
   logic            unused_hi;

   assign unused_hi = ^wdata[DATA_W-1:XT_W];

   // the extra divisor LSB only follows the data when the same write selects the undivided PLL
   always_comb begin
      ext_next = wdata[XT_W-1:0];
      if (!wdata[XT_D400]) ext_next[XT_LSB] = ext_r[XT_LSB];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         leg_r <= LG_RST;
         ext_r <= XT_RST;
      end else begin
         if (wr_legacy) leg_r <= wdata[LG_W-1:0];
         if (wr_ext)    ext_r <= ext_next;
      end
   end

endmodule

// File: rtl/sysclk_cfg_resolve.sv
module sysclk_cfg_resolve
   import sysclk_seldiv_pkg::*;
(
   input  logic [LG_W-1:0] leg_r,
   input  logic [XT_W-1:0] ext_r,
   output eff_cfg_t        cand,
   output logic            cand_bad
);

   logic              ovr, byp, pdn, d400, den;
   logic [SRC_W-1:0]  src;
   logic [XDIV_W-1:0] field;
   logic [EDIV_W-1:0] div7;
   logic              unused_moff;

   assign unused_moff = leg_r[LG_MOFF];

   always_comb begin
      ovr = ext_r[XT_OVR];
      den = leg_r[LG_DEN];
      if (ovr) begin
         src   = ext_r[XT_SRC +: SRC_W];
         byp   = ext_r[XT_BYP];
         pdn   = ext_r[XT_PDN];
         d400  = ext_r[XT_D400];
         field = ext_r[XT_DIV +: XDIV_W];
         div7  = d400 ? {field, ext_r[XT_LSB]} : {1'b0, field};
      end else begin
         src   = {1'b0, leg_r[LG_SRC +: 2]};
         byp   = leg_r[LG_BYP];
         pdn   = leg_r[LG_PDN];
         d400  = 1'b0;
         field = XDIV_W'(leg_r[LG_DIV +: LDIV_W]);
         div7  = {1'b0, field};
      end
      cand.src     = src;
      cand.pll     = !byp;
      cand.pll_off = pdn;
      cand.raw_pll = d400 && !byp;
      cand.div     = (!byp || den) ? div7 : '0;
      cand_bad     = src_reserved(src) ||
                     (!byp && (field < XDIV_W'(PLL_MIN_FIELD)));
   end

endmodule

// File: rtl/sysclk_tick_div.sv
module sysclk_tick_div
   import sysclk_seldiv_pkg::*;
#(
   parameter int INT_QDIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  src,
   input  logic              pll,
   input  logic              raw_pll,
   input  logic [EDIV_W-1:0] div,
   input  logic              restart,
   input  logic              tick_main,
   input  logic              tick_int,
   input  logic              tick_lfo,
   input  logic              tick_x32k,
   input  logic              tick_pll,
   output logic              clk_en
);

   logic              int_q_tick;
   logic              pll_half;
   logic              pll_slow;
   logic              sel_tick;
   logic [EDIV_W-1:0] cnt;

   if (INT_QDIV > 1) begin : g_qdiv
      localparam int QW = $clog2(INT_QDIV);
      localparam logic [QW-1:0] QLAST = QW'(INT_QDIV - 1);
      logic [QW-1:0] qc;
      always_ff @(posedge clk) begin
         if (!rst_n)        qc <= '0;
         else if (tick_int) qc <= (qc == QLAST) ? '0 : qc + 1'b1;
      end
      assign int_q_tick = tick_int && (qc == QLAST);
   end else begin : g_qpass
      assign int_q_tick = tick_int;
   end

   // fixed divide-by-2 ahead of the PLL divisor
   always_ff @(posedge clk) begin
      if (!rst_n)        pll_half <= 1'b0;
      else if (tick_pll) pll_half <= !pll_half;
   end
   assign pll_slow = tick_pll && pll_half;

   always_comb begin
      if (pll) begin
         sel_tick = raw_pll ? tick_pll : pll_slow;
      end else begin
         unique case (src)
            SRC_MAIN: sel_tick = tick_main;
            SRC_INT:  sel_tick = tick_int;
            SRC_INTQ: sel_tick = int_q_tick;
            SRC_LFO:  sel_tick = tick_lfo;
            SRC_X32K: sel_tick = tick_x32k;
            default:  sel_tick = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         clk_en <= 1'b0;
      end else if (restart) begin
         cnt    <= '0;
         clk_en <= 1'b0;
      end else begin
         clk_en <= sel_tick && (cnt == div);
         if (sel_tick) cnt <= (cnt == div) ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sysclk_seldiv.sv
module sysclk_seldiv
   import sysclk_seldiv_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int LOCK_STAGES = 2,
   parameter int INT_QDIV    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_legacy,
   input  logic              wr_ext,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tick_main,
   input  logic              tick_int,
   input  logic              tick_lfo,
   input  logic              tick_x32k,
   input  logic              tick_pll,
   input  logic              pll_locked,
   output logic              clk_en,
   output logic [2:0]        eff_src,
   output logic              eff_pll,
   output logic              eff_pll_off,
   output logic [6:0]        eff_div,
   output logic              cfg_err,
   output logic [7:0]        raw_status,
   output logic              main_osc_off,
   output logic [DATA_W-1:0] legacy_q,
   output logic [DATA_W-1:0] ext_q
);

   localparam int LOCK_BIT = 6;

   if (DATA_W < XT_W) begin : g_bad_dw
      $error("DATA_W too narrow for the extended word");
   end
   if (LOCK_STAGES < 1) begin : g_bad_lk
      $error("LOCK_STAGES must be at least 1");
   end
   if (INT_QDIV < 1) begin : g_bad_q
      $error("INT_QDIV must be at least 1");
   end
   if (EDIV_W != 7 || SRC_W != 3) begin : g_bad_w
      $error("status port widths assume a 7-bit divisor and 3-bit source");
   end

   logic [LG_W-1:0]        leg_r;
   logic [XT_W-1:0]        ext_r;
   eff_cfg_t               cand;
   eff_cfg_t               eff_q;
   logic                   cand_bad;
   logic                   restart;
   logic [LOCK_STAGES-1:0] lk_sr;

   sysclk_cfg_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_legacy (wr_legacy),
      .wr_ext    (wr_ext),
      .wdata     (wdata),
      .leg_r     (leg_r),
      .ext_r     (ext_r)
   );

   sysclk_cfg_resolve u_resolve (
      .leg_r    (leg_r),
      .ext_r    (ext_r),
      .cand     (cand),
      .cand_bad (cand_bad)
   );

   // hold the last legal configuration; report a reserved one
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eff_q   <= EFF_RST;
         cfg_err <= 1'b0;
      end else begin
         if (!cand_bad) eff_q <= cand;
         cfg_err <= cand_bad;
      end
   end

   assign restart = !cand_bad && (cand != eff_q);

   sysclk_tick_div #(.INT_QDIV(INT_QDIV)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (eff_q.src),
      .pll       (eff_q.pll),
      .raw_pll   (eff_q.raw_pll),
      .div       (eff_q.div),
      .restart   (restart),
      .tick_main (tick_main),
      .tick_int  (tick_int),
      .tick_lfo  (tick_lfo),
      .tick_x32k (tick_x32k),
      .tick_pll  (tick_pll),
      .clk_en    (clk_en)
   );

   if (LOCK_STAGES == 1) begin : g_lk1
      always_ff @(posedge clk) begin
         if (!rst_n) lk_sr <= '0;
         else        lk_sr <= pll_locked;
      end
   end else begin : g_lkn
      always_ff @(posedge clk) begin
         if (!rst_n) lk_sr <= '0;
         else        lk_sr <= {lk_sr[LOCK_STAGES-2:0], pll_locked};
      end
   end

   always_comb begin
      raw_status           = '0;
      raw_status[LOCK_BIT] = lk_sr[LOCK_STAGES-1];
   end

   assign eff_src      = eff_q.src;
   assign eff_pll      = eff_q.pll;
   assign eff_pll_off  = eff_q.pll_off;
   assign eff_div      = eff_q.div;
   assign main_osc_off = leg_r[LG_MOFF];
   assign legacy_q     = DATA_W'(leg_r);
   assign ext_q        = DATA_W'(ext_r);

endmodule

// File: rtl/sysclk_seldiv_chk.sv
module sysclk_seldiv_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_ext,
   input logic       wr_d400,
   input logic       lsb_q,
   input logic       ovr_q,
   input logic [2:0] eff_src,
   input logic       eff_pll,
   input logic [6:0] eff_div,
   input logic       cfg_err,
   input logic       clk_en,
   input logic [7:0] raw_status
);

   // R9 and R2: an error cycle keeps the effective configuration
   p_hold_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> ($stable(eff_div) && $stable(eff_src) && $stable(eff_pll)));

   // R7: the extra LSB survives a write that does not select the undivided PLL
   p_lsb_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ext && !wr_d400) |=> $stable(lsb_q));

   // R9: the PLL path never runs with a divisor below 2
   p_pll_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eff_pll |-> (eff_div >= 7'd2));

   // R11: with a ratio above one the enable never lasts two cycles
   p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && eff_div != 7'd0) |=> !clk_en);

   // R10: spare status bits stay low
   p_status_spare_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_status[5:0] == 6'd0) && !raw_status[7]);

   // R3: without override the 32 kHz code cannot become effective
   p_ext_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ovr_q) && !cfg_err) |-> !eff_src[2]);

endmodule

bind sysclk_seldiv sysclk_seldiv_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_ext     (wr_ext),
   .wr_d400    (wdata[sysclk_seldiv_pkg::XT_D400]),
   .lsb_q      (ext_q[sysclk_seldiv_pkg::XT_LSB]),
   .ovr_q      (ext_q[sysclk_seldiv_pkg::XT_OVR]),
   .eff_src    (eff_src),
   .eff_pll    (eff_pll),
   .eff_div    (eff_div),
   .cfg_err    (cfg_err),
   .clk_en     (clk_en),
   .raw_status (raw_status)
);

// File: tb/tb_sysclk_seldiv.sv
`timescale 1ns/1ps
module tb_sysclk_seldiv;

   localparam int DW = 32;
   localparam int LK = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_legacy = 1'b0, wr_ext = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic          tick_main = 1'b1, tick_int = 1'b1, tick_pll = 1'b1;
   logic          tick_lfo = 1'b0, tick_x32k = 1'b0;
   logic          pll_locked = 1'b0;
   logic          clk_en, eff_pll, eff_pll_off, cfg_err, main_osc_off;
   logic [2:0]    eff_src;
   logic [6:0]    eff_div;
   logic [7:0]    raw_status;
   logic [DW-1:0] legacy_q, ext_q;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = !clk;

   sysclk_seldiv #(.DATA_W(DW), .LOCK_STAGES(LK), .INT_QDIV(4)) dut (
      .clk(clk), .rst_n(rst_n), .wr_legacy(wr_legacy), .wr_ext(wr_ext),
      .wdata(wdata), .tick_main(tick_main), .tick_int(tick_int),
      .tick_lfo(tick_lfo), .tick_x32k(tick_x32k), .tick_pll(tick_pll),
      .pll_locked(pll_locked), .clk_en(clk_en), .eff_src(eff_src),
      .eff_pll(eff_pll), .eff_pll_off(eff_pll_off), .eff_div(eff_div),
      .cfg_err(cfg_err), .raw_status(raw_status), .main_osc_off(main_osc_off),
      .legacy_q(legacy_q), .ext_q(ext_q)
   );

   // low-frequency source ticks every 2nd cycle, 32 kHz source every 3rd
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph = (ph + 1) % 6;
         tick_lfo  = (ph % 2) == 0;
         tick_x32k = (ph % 3) == 0;
      end
   end

   typedef struct packed {
      logic [15:0] leg;
      logic [15:0] ext;
      logic [6:0]  div;
      logic [2:0]  src;
      logic        pll;
      logic        err;
      logic [7:0]  per;
   } vec_t;

   localparam vec_t TBL [14] = '{
      '{16'h0143, 16'h0000, 7'd3,  3'd0, 1'b0, 1'b0, 8'd4},   // R5 R4 main /4
      '{16'h0043, 16'h0000, 7'd0,  3'd0, 1'b0, 1'b0, 8'd1},   // R8 undivided
      '{16'h0161, 16'h0000, 7'd1,  3'd2, 1'b0, 1'b0, 8'd8},   // R2 internal/4 then /2
      '{16'h0004, 16'h0000, 7'd4,  3'd0, 1'b1, 1'b0, 8'd10},  // R4 R8 PLL/2 /5 forced
      '{16'h0100, 16'h2409, 7'd9,  3'd0, 1'b0, 1'b0, 8'd10},  // R3 override main /10
      '{16'h0100, 16'h3042, 7'd5,  3'd0, 1'b1, 1'b0, 8'd6},   // R6 7-bit divisor
      '{16'h0100, 16'h2042, 7'd2,  3'd0, 1'b1, 1'b0, 8'd6},   // R6 LSB ignored
      '{16'h0100, 16'h243F, 7'd63, 3'd0, 1'b0, 1'b0, 8'd64},  // R5 widest divisor
      '{16'h0100, 16'h2001, 7'd63, 3'd0, 1'b0, 1'b1, 8'd64},  // R9 ext PLL field 1
      '{16'h0100, 16'h2683, 7'd63, 3'd0, 1'b0, 1'b1, 8'd64},  // R2 reserved source 5
      '{16'h0000, 16'h0000, 7'd63, 3'd0, 1'b0, 1'b1, 8'd64},  // R9 legacy PLL field 0
      '{16'h0146, 16'h0401, 7'd6,  3'd0, 1'b0, 1'b0, 8'd7},   // R3 ext ignored
      '{16'h0100, 16'h2780, 7'd0,  3'd7, 1'b0, 1'b0, 8'd3},   // R2 32 kHz source
      '{16'h0172, 16'h0000, 7'd2,  3'd3, 1'b0, 1'b0, 8'd6}    // R2 low-frequency source
   };

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic write_word(input bit to_ext, input logic [DW-1:0] d);
      @(negedge clk);
      wdata     = d;
      wr_legacy = !to_ext;
      wr_ext    = to_ext;
      @(negedge clk);
      wr_legacy = 1'b0;
      wr_ext    = 1'b0;
   endtask

   task automatic measure(output int per);
      int n = 0;
      per = -1;
      while (!clk_en && n < 400) begin @(negedge clk); n++; end
      if (!clk_en) return;
      @(negedge clk);
      n = 1;
      while (!clk_en && n < 400) begin @(negedge clk); n++; end
      if (clk_en) per = n;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int per;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(legacy_q == 32'h2DF, "R1 legacy word", legacy_q, 32'h2DF);
      check(ext_q == 32'hC8F, "R1 extended word", ext_q, 32'hC8F);
      check(eff_src == 3'd1, "R1 source", eff_src, 1);
      check(eff_div == 7'd0 && !eff_pll, "R1 divisor/path", {eff_pll, eff_div}, 0);
      check(eff_pll_off && main_osc_off, "R1 power-down/main off", {eff_pll_off, main_osc_off}, 3);
      check(!cfg_err && raw_status == 8'h00, "R1 err/status", {cfg_err, raw_status}, 0);

      // R10 lock mirror latency
      pll_locked = 1'b1;
      @(negedge clk);
      check(raw_status == 8'h00, "R10 lock not yet", raw_status, 0);
      @(negedge clk);
      check(raw_status == 8'h40, "R10 lock bit 6", raw_status, 8'h40);

      // table of configurations
      for (int i = 0; i < 14; i++) begin
         write_word(1'b0, DW'(TBL[i].leg));
         write_word(1'b1, DW'(TBL[i].ext));
         repeat (3) @(negedge clk);
         check(eff_div == TBL[i].div, $sformatf("R5 vec%0d eff_div", i), eff_div, TBL[i].div);
         check(eff_src == TBL[i].src, $sformatf("R2 vec%0d eff_src", i), eff_src, TBL[i].src);
         check(eff_pll == TBL[i].pll, $sformatf("R4 vec%0d eff_pll", i), eff_pll, TBL[i].pll);
         check(cfg_err == TBL[i].err, $sformatf("R9 vec%0d cfg_err", i), cfg_err, TBL[i].err);
         measure(per);
         check(per == int'(TBL[i].per), $sformatf("R11 vec%0d period", i), per, TBL[i].per);
      end

      // R7 extra LSB write guard (stored LSB is 1 here)
      write_word(1'b1, 32'h0000);
      check(ext_q == 32'h0040, "R7 lsb kept", ext_q, 32'h0040);
      write_word(1'b1, 32'h1000);
      check(ext_q == 32'h1000, "R7 lsb cleared with bit 12", ext_q, 32'h1000);
      write_word(1'b1, 32'h0040);
      check(ext_q == 32'h0000, "R7 lsb not set without bit 12", ext_q, 32'h0000);
      write_word(1'b1, 32'h1040);
      check(ext_q == 32'h1040, "R7 lsb set with bit 12", ext_q, 32'h1040);
      write_word(1'b1, 32'h0000);
      repeat (3) @(negedge clk);

      // R12 latency and R11 restart
      @(negedge clk);
      wdata = 32'h0145;
      wr_legacy = 1'b1;
      @(negedge clk);
      wr_legacy = 1'b0;
      check(legacy_q == 32'h145 && eff_div == 7'd2, "R12 readback before effective",
            {legacy_q[15:0], 1'b0, eff_div}, {16'h0145, 8'd2});
      @(negedge clk);
      check(eff_div == 7'd5, "R12 effective update", eff_div, 5);
      begin
         int k = 0;
         while (!clk_en && k < 100) begin @(negedge clk); k++; end
         check(k == 6, "R11 restart to first pulse", k, 6);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule